// File: doc/BRIEF.md
# Slow-Tick Register Write Synchronizer

This block stands between a fast host bus and the registers of a timekeeping domain that updates only on a slow tick. A host write aimed at one of those registers is captured together with its register select code and parked in a single holding slot. The parked write is then delivered to the slow domain on the next commit tick, as a one-cycle commit pulse that carries the held select and data. A status word reports a busy bit while the slot is occupied and a done bit once the write has landed. The done bit can drive an interrupt.

The commit tick comes from one of two pulse inputs. When the prescale control is high, the slow divided tick is used. When it is low, every edge of the raw low-frequency oscillator is used. Only one write can be outstanding at a time. A further synced write that arrives while the slot is busy is thrown away and no error is reported. Software is expected to poll the busy bit, or wait for the done interrupt, before it issues the next write.

Writes to the status register do not go through the slot. They clear status bits at the next clock edge, whatever the state of the slot.

Top module: `slowreg_write_sync`

## Requirements
- R1: After reset, the status word reads 0, irq is low and commit_valid is low.
- R2: A synced write (wr_en high, wr_sel not equal to 7) accepted while idle sets status bit 14 (busy) from the next clock cycle onward.
- R3: On the first clock edge that sees the selected tick while busy, the block produces a single-cycle commit_valid pulse carrying the held select and data. In that same cycle, bit 14 reads 0 and bit 15 (done) reads 1.
- R4: A synced write that arrives while busy is discarded. The commit that follows carries the first write, and no second commit is produced.
- R5: With prescale_en at 1, only tick_slow commits. With prescale_en at 0, only tick_fast commits. The tick that is not selected has no effect.
- R6: A write accepted in the same cycle as a selected tick, with nothing pending, is not committed by that tick. It waits for the next selected tick.
- R7: A write with wr_sel equal to 7 is a status write. If wr_data bit 15 is 1, the done bit clears at the next edge. If wr_data bit 15 is 0, the done bit is left as it is. A status write never changes the busy bit or the held write.
- R8: If a commit and a status write that clears done fall on the same edge, done ends up set.
- R9: irq is high exactly when the done bit is set and irq_en is high.
- R10: Reset while busy drops the held write. No commit follows on a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale_en | input | 1 | 1: commit on tick_slow; 0: commit on tick_fast |
| tick_slow | input | 1 | One-cycle pulse per divided slow tick |
| tick_fast | input | 1 | One-cycle pulse per raw oscillator edge |
| irq_en | input | 1 | Done-interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Target register code; 7 selects the status register |
| wr_data | input | 32 | Host write data |
| commit_valid | output | 1 | One-cycle pulse delivering the held write |
| commit_sel | output | 3 | Register code of the committed write |
| commit_data | output | 32 | Data of the committed write |
| status | output | 16 | Bit 15 done, bit 14 busy, other bits 0 |
| irq | output | 1 | Done interrupt |

## Verification
Two pairs of functions can land on the same edge. The first pair is a commit, which sets done, and a status write that clears done. The bench provokes this by driving a status write with bit 15 set during the very cycle in which it pulses the selected tick for a pending write, and it expects done to remain set. The second pair is an accept and a tick: a synced write is driven in the same cycle as a selected tick while the slot is idle. The bench then checks that busy is raised, that no commit pulse appears, and that the scoreboard receives the write only after a later tick.

// File: rtl/swsync_pkg.sv
package swsync_pkg;
  localparam int STS_W    = 16;
  localparam int BUSY_BIT = 14;
  localparam int DONE_BIT = 15;

  function automatic logic pick_tick(input logic prescale, input logic slow, input logic fast);
    return prescale ? slow : fast;
  endfunction

  function automatic logic is_status_code(input logic [7:0] sel, input logic [7:0] code);
    return sel == code;
  endfunction

  function automatic logic [STS_W-1:0] pack_status(input logic done, input logic busy);
    logic [STS_W-1:0] s;
    s = '0;
    s[DONE_BIT] = done;
    s[BUSY_BIT] = busy;
    return s;
  endfunction
endpackage

// File: rtl/swsync_tick_pick.sv
module swsync_tick_pick (
  input  logic prescale_en,
  input  logic tick_slow,
  input  logic tick_fast,
  output logic tick_sel
);
  import swsync_pkg::*;
  always_comb tick_sel = pick_tick(prescale_en, tick_slow, tick_fast);
endmodule

// File: rtl/swsync_holder.sv
module swsync_holder #(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_sel,
  input  logic              wr_en,
  input  logic              is_sts,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              commit_ev,
  output logic              commit_valid,
  output logic [SEL_W-1:0]  commit_sel,
  output logic [DATA_W-1:0] commit_data
);
  logic              pending_q;
  logic [SEL_W-1:0]  hold_sel_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              accept_ev;

  always_comb begin
    accept_ev = wr_en && !is_sts && !pending_q;
    commit_ev = pending_q && tick_sel;
    busy      = pending_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q    <= 1'b0;
      hold_sel_q   <= '0;
      hold_data_q  <= '0;
      commit_valid <= 1'b0;
      commit_sel   <= '0;
      commit_data  <= '0;
    end else begin
      commit_valid <= commit_ev;
      if (commit_ev) begin
        commit_sel  <= hold_sel_q;
        commit_data <= hold_data_q;
        pending_q   <= 1'b0;
      end else if (accept_ev) begin
        hold_sel_q  <= wr_sel;
        hold_data_q <= wr_data;
        pending_q   <= 1'b1;
      end
    end
  end

  p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);
  p_commit_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !pending_q);
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !tick_sel) |=> (pending_q && $stable(hold_data_q) && $stable(hold_sel_q)));
  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && wr_en && !is_sts) |=> $stable(hold_data_q));
endmodule

// File: rtl/swsync_flags.sv
module swsync_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic irq_en,
  output logic done,
  output logic irq
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      done_q <= 1'b0;
    else if (set_ev) done_q <= 1'b1;
    else if (clr_ev) done_q <= 1'b0;
  end

  always_comb begin
    done = done_q;
    irq  = done_q && irq_en;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> done_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !done_q);
endmodule

// File: rtl/slowreg_write_sync.sv
module slowreg_write_sync #(
  parameter int SEL_W    = 3,
  parameter int DATA_W   = 32,
  parameter int STS_CODE = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         prescale_en,
  input  logic                         tick_slow,
  input  logic                         tick_fast,
  input  logic                         irq_en,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         commit_valid,
  output logic [SEL_W-1:0]             commit_sel,
  output logic [DATA_W-1:0]            commit_data,
  output logic [swsync_pkg::STS_W-1:0] status,
  output logic                         irq
);
  import swsync_pkg::*;

  logic tick_sel, is_sts, sts_clr_ev, commit_ev, busy, done;

  always_comb begin
    is_sts     = is_status_code(8'(wr_sel), 8'(STS_CODE));
    sts_clr_ev = wr_en && is_sts && wr_data[DONE_BIT];
    status     = pack_status(done, busy);
  end

  swsync_tick_pick u_tick (
    .prescale_en(prescale_en), .tick_slow(tick_slow), .tick_fast(tick_fast), .tick_sel(tick_sel)
  );

  swsync_holder #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .wr_en(wr_en), .is_sts(is_sts),
    .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy), .commit_ev(commit_ev),
    .commit_valid(commit_valid), .commit_sel(commit_sel), .commit_data(commit_data)
  );

  swsync_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(commit_ev), .clr_ev(sts_clr_ev),
    .irq_en(irq_en), .done(done), .irq(irq)
  );

  p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[DONE_BIT]);
  p_commit_sets_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> status[DONE_BIT]);
  p_busy_survives_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_sel && wr_en && is_sts) |=> status[BUSY_BIT]);
endmodule

// File: tb/sim_slowreg_write_sync.sv
`timescale 1ns/1ps
module sim_slowreg_write_sync;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prescale_en = 1'b1, tick_slow = 1'b0, tick_fast = 1'b0, irq_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic commit_valid, irq;
  logic [2:0] commit_sel;
  logic [31:0] commit_data;
  logic [15:0] status;

  typedef struct packed { logic [2:0] sel; logic [31:0] data; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  slowreg_write_sync u0 (
    .clk(clk), .rst_n(rst_n), .prescale_en(prescale_en), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .irq_en(irq_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .commit_valid(commit_valid), .commit_sel(commit_sel),
    .commit_data(commit_data), .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, optional write and ticks together
  task automatic cyc(input bit w, input logic [2:0] s, input logic [31:0] d,
                     input bit ts, input bit tf, input bit expect_push);
    wr_en = w; wr_sel = s; wr_data = d; tick_slow = ts; tick_fast = tf;
    if (expect_push) exp_q.push_back({s, d});
    @(negedge clk);
    wr_en = 0; tick_slow = 0; tick_fast = 0;
  endtask

  // monitor: scoreboard compare on every commit
  always @(negedge clk) begin
    if (rst_n && commit_valid) begin
      if (exp_q.size() == 0) chk(0, "R4/R10 unexpected commit", {29'b0, commit_sel}, 32'hx);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(commit_sel == e.sel, "R3 commit_sel", {29'b0, commit_sel}, {29'b0, e.sel});
        chk(commit_data == e.data, "R3 commit_data", commit_data, e.data);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_run) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 16'h0, "R1 status", status, 0);
    chk(!irq, "R1 irq", irq, 0);
    chk(!commit_valid, "R1 commit", commit_valid, 0);

    // R2 accept
    cyc(1, 3'd1, 32'hA5A5_0001, 0, 0, 1);
    chk(status == 16'h4000, "R2 busy", status, 16'h4000);
    // R5 unselected tick ignored
    cyc(0, 0, 0, 0, 1, 0);
    chk(!commit_valid && status == 16'h4000, "R5 fast tick ignored", status, 16'h4000);
    // R4 dropped write
    cyc(1, 3'd2, 32'hDEAD_BEEF, 0, 0, 0);
    // R7 status write while busy keeps busy
    cyc(1, 3'd7, 32'h0000_8000, 0, 0, 0);
    chk(status == 16'h4000, "R7 busy untouched", status, 16'h4000);
    // R3 commit
    cyc(0, 0, 0, 1, 0, 0);
    chk(commit_valid == 1, "R3 pulse", commit_valid, 1);
    chk(status == 16'h8000, "R3 status after commit", status, 16'h8000);
    chk(!irq, "R9 irq masked", irq, 0);
    repeat (4) cyc(0, 0, 0, 1, 1, 0);
    chk(!commit_valid && exp_q.size() == 0, "R4 no second commit", exp_q.size(), 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq == 1, "R9 irq on", irq, 1);
    // R7 clear semantics
    cyc(1, 3'd7, 32'hFFFF_7FFF, 0, 0, 0);
    chk(status == 16'h8000, "R7 bit15=0 keeps done", status, 16'h8000);
    cyc(1, 3'd7, 32'h0000_8000, 0, 0, 0);
    chk(status == 16'h0, "R7 clear done", status, 0);
    chk(!irq, "R9 irq off", irq, 0);

    // R5 fast mode
    prescale_en = 0;
    cyc(1, 3'd3, 32'h1234_5678, 0, 0, 1);
    cyc(0, 0, 0, 1, 0, 0);
    chk(!commit_valid && status == 16'h4000, "R5 slow tick ignored", status, 16'h4000);
    cyc(0, 0, 0, 0, 1, 0);
    chk(commit_valid == 1, "R5 fast commit", commit_valid, 1);
    cyc(1, 3'd7, 32'h8000, 0, 0, 0);

    // R6 accept together with tick
    cyc(1, 3'd4, 32'h0BAD_F00D, 0, 1, 1);
    chk(!commit_valid && status == 16'h4000, "R6 held past same-cycle tick", status, 16'h4000);
    cyc(0, 0, 0, 0, 1, 0);
    chk(commit_valid == 1, "R6 later commit", commit_valid, 1);

    // R8 commit and clear on same edge (done already set)
    cyc(1, 3'd5, 32'hCAFE_0005, 0, 0, 1);
    wr_en = 1; wr_sel = 3'd7; wr_data = 32'h8000; tick_fast = 1;
    @(negedge clk);
    wr_en = 0; tick_fast = 0;
    chk(status == 16'h8000, "R8 set wins", status, 16'h8000);

    // R10 reset while busy
    cyc(1, 3'd6, 32'h6666_6666, 0, 0, 0);
    chk(status[14] == 1, "R10 busy before reset", status, 16'h4000);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) cyc(0, 0, 0, 1, 1, 0);
    chk(!commit_valid && status == 16'h0, "R10 held write dropped", status, 0);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule